// File: doc/BRIEF.md
# Cascaded Free-Running Wide Counter

This block keeps a free-running count for timekeeping. In its cascaded form it has two counter channels of `CH_WIDTH` bits each. The low channel advances once per `PRESCALE_DIV` clocks. It also drives a square-wave output that is high while the low count is in the lower half of its range and low while it is in the upper half. That output therefore rises exactly once per wrap of the low channel.

The high channel counts those rising edges. It sees them in the master clock domain and advances one clock after the low channel lands on zero. Software builds the wide value from the high count as the upper half and the low count as the lower half. A synchronising request clears every channel and the prescaler in the same clock.

Setting `NATIVE_WIDE` replaces the pair with one counter of twice the channel width. In that mode the second channel is not used. No interrupt path exists in either form.

Top module: `cascade_counter32`

## Requirements
- R1: While `rst_n` is low and right after its release, every count is zero. `waveOut` is high in cascaded mode and low in native mode.
- R2: With no sync request, the low count advances by one on every `PRESCALE_DIV`-th rising clock edge after reset. The first advance comes on edge number `PRESCALE_DIV`.
- R3: The low channel wraps from its all-ones value to zero and keeps counting.
- R4: In cascaded mode, `waveOut` is set when the low count becomes 0 and cleared when it becomes 2^(CH_WIDTH-1). It is therefore high exactly while the low count is below 2^(CH_WIDTH-1).
- R5: In cascaded mode, the high count advances by exactly one per rise of `waveOut`. The advance takes effect on the clock edge after the one at which the low count became zero. It does not change at any other time.
- R6: `countAll` always equals `{countHi, countLo}` in cascaded mode.
- R7: A clock edge that samples `syncReq` high leaves the prescaler, the low count and the high count all at zero, and `waveOut` high in cascaded mode. A high-count advance that was due on that same edge is discarded.
- R8: With `NATIVE_WIDE` set, `countAll` is a single counter of 2*CH_WIDTH bits that follows the R2 cadence. `countLo` is its lower half, `countHi` stays zero and `waveOut` stays low.
- R9: Between two syncs, a wide value taken from a consistent read never falls below the previous consistent read. A read is consistent when `countHi` is the same on that clock and on the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| syncReq | input | 1 | Clears all channels together when sampled high |
| countLo | output | CH_WIDTH | Low channel count, or lower half of the native counter |
| countHi | output | CH_WIDTH | High channel count; zero in native mode |
| countAll | output | 2*CH_WIDTH | Combined wide count |
| waveOut | output | 1 | Low channel half-range square wave; low in native mode |

## Verification
The assertions assume that `syncReq` is a clean synchronous level that changes only away from the clock edge. They also assume that `rst_n` is held low from time zero until the first edges have passed. The bench drives `syncReq` only on falling edges and keeps it high for exactly one rising edge per request. One request lands on the edge where a high-count advance is pending, so the discard path is exercised. The bench runs both configurations with narrow 8-bit channels and a prescale of 4, so the low channel wraps several times within the run.

// File: rtl/cc32_pkg.sv
`timescale 1ns/1ps
package cc32_pkg;
  // Strobes from the control to the datapath, valid for one clock.
  typedef struct packed {
    logic sync;    // clear every channel
    logic loStep;  // advance the low channel (or the native counter)
    logic hiStep;  // advance the high channel
  } ctrl_strobe_t;
endpackage

// File: rtl/cc32_ctrl.sv
`timescale 1ns/1ps
module cc32_ctrl
  import cc32_pkg::*;
#(
  parameter int PRESCALE_DIV = 8,
  parameter bit NATIVE_WIDE  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         syncReq,
  input  logic         waveIn,
  output ctrl_strobe_t strobes
);

  logic tick;

  generate
    if (PRESCALE_DIV <= 1) begin : gNoDiv
      assign tick = 1'b1;
    end else begin : gDiv
      localparam int PreW = $clog2(PRESCALE_DIV);
      localparam logic [PreW-1:0] PreLast = PreW'(PRESCALE_DIV - 1);
      logic [PreW-1:0] preQ;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              preQ <= '0;
        else if (syncReq)        preQ <= '0;
        else if (preQ == PreLast) preQ <= '0;
        else                     preQ <= preQ + PreW'(1);
      end

      assign tick = (preQ == PreLast);

      AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        preQ <= PreLast); // R2
      AST_PRE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        syncReq |=> (preQ == '0)); // R7
    end
  endgenerate

  // Rising-edge detector on the routed waveform, in the master clock domain.
  logic wavePrevQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wavePrevQ <= 1'b1;
    else if (syncReq) wavePrevQ <= 1'b1;
    else              wavePrevQ <= waveIn;
  end

  logic hiEdge;
  assign hiEdge = waveIn & ~wavePrevQ & ~NATIVE_WIDE;

  assign strobes.sync   = syncReq;
  assign strobes.loStep = tick & ~syncReq;
  assign strobes.hiStep = hiEdge & ~syncReq;

  AST_HI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.hiStep |=> !strobes.hiStep); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.sync |-> !(strobes.loStep || strobes.hiStep)); // R7

endmodule

// File: rtl/cc32_datapath.sv
`timescale 1ns/1ps
module cc32_datapath
  import cc32_pkg::*;
#(
  parameter int CH_WIDTH    = 16,
  parameter bit NATIVE_WIDE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrl_strobe_t          strobes,
  output logic [CH_WIDTH-1:0]   countLo,
  output logic [CH_WIDTH-1:0]   countHi,
  output logic [2*CH_WIDTH-1:0] countAll,
  output logic                  waveOut
);

  localparam int WideW = 2 * CH_WIDTH;
  localparam logic [CH_WIDTH-1:0] LoMax    = '1;
  localparam logic [CH_WIDTH-1:0] HalfMark = {1'b1, {(CH_WIDTH-1){1'b0}}};

  generate
    if (NATIVE_WIDE) begin : gNative
      logic [WideW-1:0] wideQ;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              wideQ <= '0;
        else if (strobes.sync)   wideQ <= '0;
        else if (strobes.loStep) wideQ <= wideQ + WideW'(1);
      end

      assign countLo  = wideQ[CH_WIDTH-1:0];
      assign countHi  = '0;
      assign countAll = wideQ;
      assign waveOut  = 1'b0;

      AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes.loStep && !strobes.sync) |=> (wideQ == $past(wideQ) + WideW'(1))); // R8
      AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobes.loStep && !strobes.sync) |=> $stable(wideQ)); // R2
      AST_WIDE_NO_HI: assert property (@(posedge clk) disable iff (!rst_n)
        !strobes.hiStep); // R8
    end else begin : gCascade
      logic [CH_WIDTH-1:0] ch0Q;
      logic [CH_WIDTH-1:0] ch1Q;
      logic [CH_WIDTH-1:0] ch0Next;
      logic                waveQ;

      assign ch0Next = ch0Q + CH_WIDTH'(1);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              ch0Q <= '0;
        else if (strobes.sync)   ch0Q <= '0;
        else if (strobes.loStep) ch0Q <= ch0Next;
      end

      // Compare-driven waveform: set at count zero, cleared at the half mark.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            waveQ <= 1'b1;
        else if (strobes.sync) waveQ <= 1'b1;
        else if (strobes.loStep) begin
          if (ch0Next == '0)            waveQ <= 1'b1;
          else if (ch0Next == HalfMark) waveQ <= 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              ch1Q <= '0;
        else if (strobes.sync)   ch1Q <= '0;
        else if (strobes.hiStep) ch1Q <= ch1Q + CH_WIDTH'(1);
      end

      assign countLo  = ch0Q;
      assign countHi  = ch1Q;
      assign countAll = {ch1Q, ch0Q};
      assign waveOut  = waveQ;

      AST_LO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes.loStep && !strobes.sync && ch0Q == LoMax) |=> (ch0Q == '0)); // R3
      AST_WAVE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        waveQ == (ch0Q < HalfMark)); // R4
      AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobes.sync && !strobes.hiStep) |=> $stable(ch1Q)); // R5
      AST_HI_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        strobes.hiStep |-> (ch0Q == '0)); // R5
      AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        strobes.sync |=> (ch0Q == '0 && ch1Q == '0 && waveQ)); // R7
    end
  endgenerate

endmodule

// File: rtl/cascade_counter32.sv
`timescale 1ns/1ps
module cascade_counter32
  import cc32_pkg::*;
#(
  parameter int CH_WIDTH     = 16,
  parameter int PRESCALE_DIV = 8,
  parameter bit NATIVE_WIDE  = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  syncReq,
  output logic [CH_WIDTH-1:0]   countLo,
  output logic [CH_WIDTH-1:0]   countHi,
  output logic [2*CH_WIDTH-1:0] countAll,
  output logic                  waveOut
);

  ctrl_strobe_t strobes;

  cc32_ctrl #(
    .PRESCALE_DIV(PRESCALE_DIV),
    .NATIVE_WIDE (NATIVE_WIDE)
  ) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .syncReq(syncReq),
    .waveIn (waveOut),
    .strobes(strobes)
  );

  cc32_datapath #(
    .CH_WIDTH   (CH_WIDTH),
    .NATIVE_WIDE(NATIVE_WIDE)
  ) datapath_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .countLo (countLo),
    .countHi (countHi),
    .countAll(countAll),
    .waveOut (waveOut)
  );

  AST_CONCAT: assert property (@(posedge clk) disable iff (!rst_n)
    NATIVE_WIDE || (countAll == {countHi, countLo})); // R6

endmodule

// File: tb/cascade_counter32_tb_top.sv
`timescale 1ns/1ps
module cascade_counter32_tb_top;

  localparam int W   = 8;
  localparam int DIV = 4;
  localparam int LO_SPAN = 1 << W;
  localparam int WRAP_CYC = DIV * LO_SPAN;

  typedef struct { int n; bit inReset; } sb_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic syncReq;
  logic [W-1:0]   cLo, cHi, nLo, nHi;
  logic [2*W-1:0] cAll, nAll;
  logic           cWave, nWave;

  int checks = 0;
  int errors = 0;
  int n = 0;
  bit done = 1'b0;
  sb_item_t sbQ[$];

  always #10 clk = ~clk;

  cascade_counter32 #(.CH_WIDTH(W), .PRESCALE_DIV(DIV), .NATIVE_WIDE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .syncReq(syncReq),
    .countLo(cLo), .countHi(cHi), .countAll(cAll), .waveOut(cWave));

  cascade_counter32 #(.CH_WIDTH(W), .PRESCALE_DIV(DIV), .NATIVE_WIDE(1'b1)) dutNative_i (
    .clk(clk), .rst_n(rst_n), .syncReq(syncReq),
    .countLo(nLo), .countHi(nHi), .countAll(nAll), .waveOut(nWave));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: one expected item per falling edge.
  task automatic runCycles(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      n = syncReq ? 0 : n + 1;
      sbQ.push_back('{n: n, inReset: 1'b0});
    end
  endtask

  initial begin
    rst_n = 1'b0;
    syncReq = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      sbQ.push_back('{n: 0, inReset: 1'b1});
    end
    rst_n = 1'b1;
    n = 0;
    runCycles(2 * WRAP_CYC + 300);      // R2 R3 R4 R5: two full wraps
    syncReq = 1'b1;                      // R7: sync in mid count
    runCycles(1);
    syncReq = 1'b0;
    runCycles(WRAP_CYC);                 // low channel just became zero
    syncReq = 1'b1;                      // R7: sync on the edge the high step is due
    runCycles(1);
    syncReq = 1'b0;
    runCycles(2 * WRAP_CYC + 100);
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Monitor: pops expected items and compares; also tracks consistent reads.
  logic [2*W-1:0] prevAll, lastGood;
  logic [W-1:0]   prevHi;
  bit prevValid = 1'b0, goodValid = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sbQ.size() > 0) begin
        sb_item_t it;
        int eLo, eHi, eNat;
        it = sbQ.pop_front();
        eLo  = (it.n / DIV) % LO_SPAN;
        eHi  = (it.n >= 1) ? ((it.n - 1) / WRAP_CYC) % LO_SPAN : 0;
        eNat = (it.n / DIV) % (LO_SPAN * LO_SPAN);
        if (it.inReset) begin
          check("R1", "reset countAll", 32'(cAll), 32'd0);
          check("R1", "reset waveOut", 32'(cWave), 32'd1);
          check("R1", "reset native countAll", 32'(nAll), 32'd0);
          check("R1", "reset native waveOut", 32'(nWave), 32'd0);
        end else begin
          check(eLo == 0 && it.n >= DIV ? "R3" : "R2", "countLo", 32'(cLo), 32'(eLo));
          check("R4", "waveOut", 32'(cWave), (eLo < LO_SPAN / 2) ? 32'd1 : 32'd0);
          check(it.n == 0 ? "R7" : "R5", "countHi", 32'(cHi), 32'(eHi));
          check("R6", "countAll", 32'(cAll), 32'({cHi, cLo}));
          check("R8", "native countAll", 32'(nAll), 32'(eNat));
          check("R8", "native countLo", 32'(nLo), 32'(eNat % LO_SPAN));
          check("R8", "native countHi", 32'(nHi), 32'd0);
          check("R8", "native waveOut", 32'(nWave), 32'd0);
        end
        if (it.n == 0) begin
          prevValid = 1'b0;
          goodValid = 1'b0;
        end else begin
          if (prevValid && cHi == prevHi) begin
            if (goodValid) begin
              checks++;
              if (prevAll < lastGood) begin
                errors++;
                $display("FAIL R9 consistent read went back actual=%0h expected>=%0h",
                         prevAll, lastGood);
              end
            end
            lastGood  = prevAll;
            goodValid = 1'b1;
          end
          prevAll   = cAll;
          prevHi    = cHi;
          prevValid = 1'b1;
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule